// File: doc/BRIEF.md
# Slave DMA Handshake Controller

This block lets an external DMA engine move a block of bytes between a shared 8-bit bus and an internal byte-wide buffer RAM. The device side only raises a request. The external engine owns the strobes and answers each request with an acknowledge plus either a write strobe (bus into RAM) or a read strobe (RAM onto bus). One byte moves per handshake.

Software loads a base address, a byte count and a direction, then pulses start. The block asserts its active-low request and waits for an acknowledged strobe. For each completed strobe it moves one byte at the current buffer address, advances the address and lowers the remaining count. It drops the request for one clock after every byte, so a long strobe can never be counted twice. After the last byte it stays idle and gives a one-cycle done pulse for the interrupt logic. All bus inputs are taken as already synchronous to the clock.

Top module: `dma_slave_ctl`

## Requirements
- R1: After reset, drq_n_o is 1, and done_o, busy_o and bus_oe_o are 0.
- R2: A start_i pulse while idle with a nonzero count drives drq_n_o to 0 from the next cycle and raises busy_o. dir_i=0 selects bus-to-RAM (write strobe wr_n_i), and dir_i=1 selects RAM-to-bus (read strobe rd_n_i).
- R3: A byte is committed on the first clock at which the selected strobe is high, provided the previous clock saw dack_n_i and that strobe both low. Byte k of a block uses address (base + k) mod 2^AW. A later read block returns the bytes that earlier write blocks stored.
- R4: After each committed byte that is not the last, drq_n_o is 1 for exactly one cycle and is then 0 again.
- R5: The cycle after the last byte commits, done_o is 1 for one cycle, drq_n_o is 1 and busy_o is 0.
- R6: A start with count 0 gives done_o on the next cycle, and drq_n_o never goes low.
- R7: A strobe given while dack_n_i is high moves no byte and does not consume count.
- R8: The strobe of the other direction, even when acknowledged, moves no byte and does not consume count.
- R9: start_i while busy is ignored, and the running block keeps its count and direction.
- R10: bus_oe_o is 1 only during a read block while dack_n_i and rd_n_i are both low, and bus_d_o then carries the RAM byte at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that launches a block |
| dir_i | input | 1 | 0: bus to RAM, 1: RAM to bus |
| base_i | input | AW (8) | First buffer address of the block |
| count_i | input | CW (9) | Number of bytes in the block |
| dack_n_i | input | 1 | Active-low acknowledge from the DMA engine |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| bus_d_i | input | DW (8) | Bus data in |
| bus_d_o | output | DW (8) | Bus data out |
| bus_oe_o | output | 1 | Bus data output enable |
| drq_n_o | output | 1 | Active-low data request |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
If the address pointer is wrong, misplaced bytes show up as soon as the affected region is read back. The first wrong value on bus_d_o appears during that read strobe. If the remaining count is wrong, done_o arrives early or late, on the cycle after the mis-counted byte, and drq_n_o stays low or rises at the wrong time. If the edge tracking is wrong, one strobe is counted twice or an ignored strobe is accepted. Either fault shifts every later byte and moves done_o, so the next handshake exposes it.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 9;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } dma_state_e;

    typedef enum logic {
        DIR_TO_RAM   = 1'b0,
        DIR_FROM_RAM = 1'b1
    } dma_dir_e;

    function automatic logic pick_strobe(input dma_dir_e dir, input logic rd_n, input logic wr_n);
        return (dir == DIR_FROM_RAM) ? rd_n : wr_n;
    endfunction
endpackage

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
    parameter int AW = dma_pkg::ADDR_W,
    parameter int DW = dma_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/dma_strobe_det.sv
module dma_strobe_det
    import dma_pkg::*;
#(
    parameter int DW = dma_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  dma_dir_e      dir_i,
    input  logic          dack_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic [DW-1:0] bus_d_i,
    output logic          hit_o,
    output logic          act_o,
    output logic [DW-1:0] data_o
);
    logic          strb;
    logic          act_q;
    logic [DW-1:0] data_q;

    assign strb  = pick_strobe(dir_i, rd_n_i, wr_n_i);
    assign act_o = !dack_n_i && !strb;
    assign hit_o = act_q && strb;
    assign data_o = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            data_q <= '0;
        end else begin
            act_q <= act_o;
            if (act_o && dir_i == DIR_TO_RAM) data_q <= bus_d_i;
        end
    end

    assert_ack_seen_R7: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(!dack_n_i));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int AW = dma_pkg::ADDR_W,
    parameter int CW = dma_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  dma_dir_e      dir_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          hit_i,
    output logic          drq_n_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          take_o,
    output dma_dir_e      dir_o,
    output logic [AW-1:0] ptr_o
);
    dma_state_e    state_q;
    dma_dir_e      dir_q;
    logic [AW-1:0] ptr_q;
    logic [CW-1:0] rem_q;
    logic          done_q;

    assign take_o  = (state_q == ST_REQ) && hit_i;
    assign drq_n_o = (state_q != ST_REQ);
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign dir_o   = dir_q;
    assign ptr_o   = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_TO_RAM;
            ptr_q   <= '0;
            rem_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dir_q <= dir_i;
                        ptr_q <= base_i;
                        rem_q <= count_i;
                        if (count_i == '0) done_q  <= 1'b1;
                        else               state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (hit_i) begin
                        ptr_q <= ptr_q + 1'b1;
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == CW'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_GAP:  state_q <= ST_REQ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_gap_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
        take_o |=> drq_n_o);
    assert_rearm_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |=> !drq_n_o);
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (rem_q + 1'b1) == $past(rem_q));
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (drq_n_o && !busy_o));
    assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && count_i == '0) |=> (done_o && drq_n_o));
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(dir_q));
endmodule

// File: rtl/dma_slave_ctl.sv
module dma_slave_ctl
    import dma_pkg::*;
#(
    parameter int AW = dma_pkg::ADDR_W,
    parameter int CW = dma_pkg::CNT_W,
    parameter int DW = dma_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          dir_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          dack_n_i,
    input  logic          wr_n_i,
    input  logic          rd_n_i,
    input  logic [DW-1:0] bus_d_i,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_oe_o,
    output logic          drq_n_o,
    output logic          busy_o,
    output logic          done_o
);
    dma_dir_e      cur_dir;
    logic          hit, act, take;
    logic [AW-1:0] ptr;
    logic [DW-1:0] wdata, rdata;

    dma_strobe_det #(.DW(DW)) u_det (
        .clk(clk), .rst(rst), .dir_i(cur_dir), .dack_n_i(dack_n_i),
        .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .bus_d_i(bus_d_i),
        .hit_o(hit), .act_o(act), .data_o(wdata)
    );

    dma_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dma_dir_e'(dir_i)),
        .base_i(base_i), .count_i(count_i), .hit_i(hit),
        .drq_n_o(drq_n_o), .busy_o(busy_o), .done_o(done_o),
        .take_o(take), .dir_o(cur_dir), .ptr_o(ptr)
    );

    dma_buf_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we_i(take && cur_dir == DIR_TO_RAM),
        .addr_i(ptr), .wdata_i(wdata), .rdata_o(rdata)
    );

    assign bus_oe_o = busy_o && (cur_dir == DIR_FROM_RAM) && act;
    assign bus_d_o  = bus_oe_o ? rdata : '0;

    assert_oe_read_only_R10: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o |-> (!rd_n_i && !dack_n_i));
endmodule

// File: tb/sim_dma_slave_ctl.sv
module sim_dma_slave_ctl;
    logic       clk = 0, rst = 1;
    logic       start_i = 0, dir_i = 0, dack_n_i = 1, wr_n_i = 1, rd_n_i = 1;
    logic [7:0] base_i = 0, bus_d_i = 0;
    logic [8:0] count_i = 0;
    logic [7:0] bus_d_o;
    logic       bus_oe_o, drq_n_o, busy_o, done_o;

    int errors = 0, checks = 0;
    logic [7:0] mdl [256];
    logic [7:0] exp_q [$];
    logic [7:0] cur;

    always #4 clk = ~clk;

    dma_slave_ctl u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one comparison per acknowledged read strobe (R10, R3)
    bit seen = 0;
    always @(posedge clk) begin
        #2;
        if (bus_oe_o && !seen) begin
            seen = 1;
            if (exp_q.size() == 0) chk(0, "R10 unexpected output enable", 1, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(bus_d_o == e, "R3/R10 read data", bus_d_o, e);
            end
        end else if (!bus_oe_o) seen = 0;
    end

    task automatic launch(input bit d, input logic [7:0] b, input logic [8:0] n);
        @(negedge clk);
        dir_i = d; base_i = b; count_i = n; start_i = 1;
        cur = b;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 50 && drq_n_o; i++) @(negedge clk);
        chk(!drq_n_o, "R2 request present", drq_n_o, 0);
    endtask

    // one handshake; ends at the negedge after the commit edge
    task automatic xfer(input bit rd, input logic [7:0] d);
        wait_req();
        dack_n_i = 0;
        if (rd) begin rd_n_i = 0; exp_q.push_back(mdl[cur]); end
        else begin wr_n_i = 0; bus_d_i = d; mdl[cur] = d; end
        cur = cur + 1;
        @(negedge clk);
        dack_n_i = 1; rd_n_i = 1; wr_n_i = 1;
        @(negedge clk);
    endtask

    task automatic pulse(input bit ack, input bit rd);
        dack_n_i = !ack;
        if (rd) rd_n_i = 0; else wr_n_i = 0;
        bus_d_i = 8'hEE;
        repeat (2) @(negedge clk);
        dack_n_i = 1; rd_n_i = 1; wr_n_i = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(drq_n_o && !done_o && !busy_o && !bus_oe_o, "R1 reset state",
            {drq_n_o, done_o, busy_o, bus_oe_o}, 4'b1000);

        // write block of 4 bytes at 0x10
        launch(0, 8'h10, 9'd4);
        chk(!drq_n_o && busy_o, "R2 request after start", drq_n_o, 0);
        xfer(0, 8'h80);
        chk(drq_n_o, "R4 request drops after byte", drq_n_o, 1);
        @(negedge clk);
        chk(!drq_n_o, "R4 request returns", drq_n_o, 0);
        pulse(0, 0);
        chk(!drq_n_o && busy_o, "R7 strobe without ack ignored", drq_n_o, 0);
        pulse(1, 1);
        chk(!drq_n_o && !bus_oe_o, "R8 opposite strobe ignored", bus_oe_o, 0);
        @(negedge clk);
        dir_i = 1; count_i = 9'd1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        xfer(0, 8'h06);
        xfer(0, 8'h00);
        chk(!done_o && busy_o, "R9 start while busy ignored", done_o, 0);
        xfer(0, 8'h01);
        chk(done_o && drq_n_o && !busy_o, "R5 done after last byte",
            {done_o, drq_n_o, busy_o}, 3'b110);
        @(negedge clk);
        chk(!done_o, "R5 done is one cycle", done_o, 0);

        // zero-length block
        launch(1, 8'h40, 9'd0);
        chk(done_o && drq_n_o, "R6 zero count completes", {done_o, drq_n_o}, 2'b11);
        repeat (3) begin
            @(negedge clk);
            chk(drq_n_o && !busy_o, "R6 no request", drq_n_o, 1);
        end

        // wrap-around write then reads
        launch(0, 8'hFE, 9'd3);
        xfer(0, 8'hA5); xfer(0, 8'h5A); xfer(0, 8'hC3);
        chk(done_o, "R5 done after wrap block", done_o, 1);

        launch(1, 8'h10, 9'd4);
        for (int i = 0; i < 4; i++) xfer(1, 0);
        chk(done_o, "R5 done after read block", done_o, 1);
        launch(1, 8'hFE, 9'd3);
        for (int i = 0; i < 3; i++) xfer(1, 0);
        chk(!bus_oe_o, "R10 no drive when idle", bus_oe_o, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads observed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule